// File: doc/BRIEF.md
# Ethernet Transmit Buffer with Host Control Words

This block is the host side of a small Ethernet transmitter. It holds one 2 KB buffer for an outgoing frame and places three control words in the top words of the same window: a byte count, an interrupt master switch and a command/status word. The host uses a simple 32-bit single-beat bus to write the frame, set its length and issue a command. The frame occupies the buffer contiguously from offset 0: destination address, source address, type/length, then payload. Preamble, start delimiter and CRC are not stored. A command either sends the frame or loads the station address from the first six buffer bytes.

A downstream serialiser sees a request level and reads the buffer through a second read port. It ends the job with a one-cycle done strobe. Backpressure is implicit: the request stays high until done arrives, and the host cannot start a new job or change frame data in the meantime. Completion raises a one-cycle event. That event latches the interrupt output only when both the master switch and the transmit interrupt enable are set. Bus reads have one cycle of latency.

Top module: `eth_tx_buffer`

## Requirements
- R1: After reset the length, master-enable, command/status and interrupt-enable bits are all 0. `irq`, `xmit_req` and `xmit_mac` are 0.
- R2: A bus write to a word-aligned offset below 0x7E4 stores the 32-bit word in the buffer. A bus read returns the word on `bus_rdata` one cycle after `bus_rd`. Offsets 0x7E4–0x7F0 and unaligned offsets read as 0 and ignore writes.
- R3: Offset 0x7F4 holds the byte count in bits [15:0]. The count drives `xmit_len`, and bits [31:16] read as 0.
- R4: Offset 0x7F8 holds the interrupt master enable in bit 0. All other bits read as 0.
- R5: Offset 0x7FC is the command/status word: bit 0 start/busy, bit 1 address-load mode, bit 3 transmit interrupt enable. Writing bit 0 = 1 while idle raises `xmit_req`. It also sets `xmit_mac` to the written bit 1, and a read shows both bits.
- R6: Bits 0 and 1 stay at 1 while `xmit_done` is low. They clear on the edge that samples `xmit_done` high. `xmit_done` while idle has no effect, and command writes while busy leave bits 0 and 1 unchanged.
- R7: While bit 0 is 1, host writes to the frame area are discarded. Host reads of the frame area still work.
- R8: A completion latches `irq` on the same edge only if both the master enable and the transmit interrupt enable are 1.
- R9: `irq` holds until the host writes the command/status word. A completion in that same cycle wins, and `irq` stays set.
- R10: With `bus_burst` high, writes to the three control words change nothing, and reads of them return 0. Frame-area accesses are not affected by `bus_burst`.
- R11: `xmit_rd_data` returns the buffer word at `xmit_rd_addr` one cycle later, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_burst | input | 1 | Access is a beat of a burst |
| bus_addr | input | 11 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| xmit_req | output | 1 | Job pending (status bit 0) |
| xmit_mac | output | 1 | Pending job is an address load |
| xmit_len | output | 16 | Frame byte count |
| xmit_rd_addr | input | 9 | Serialiser word address |
| xmit_rd_data | output | 32 | Serialiser read data, one cycle latency |
| xmit_done | input | 1 | Job finished strobe |
| irq | output | 1 | Latched interrupt |

## Verification
The hardest case to reach is a completion strobe that lands in the same cycle as a host write to the command word, where set must win over clear. The bench drives `xmit_done` and the bus write on the same falling edge to force that case. It also sweeps all four enable combinations around a completion. Frame-area stimulus uses seeded random words at random addresses, checked against a bench model of the buffer that skips writes made while a job is pending.

// File: rtl/eth_txb_pkg.sv
package eth_txb_pkg;
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_FRAME = 3'd1,
    SEL_LEN   = 3'd2,
    SEL_GIE   = 3'd3,
    SEL_CMD   = 3'd4
  } txb_sel_e;

  localparam int CMD_GO  = 0;
  localparam int CMD_MAC = 1;
  localparam int CMD_IEN = 3;
  // words at the top of the window: command, gie, length, then four reserved
  localparam int RESERVED_WORDS = 4;
endpackage

// File: rtl/eth_txb_decode.sv
module eth_txb_decode
  import eth_txb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output txb_sel_e          sel
);
  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] W_CMD = {WA{1'b1}};
  localparam logic [WA-1:0] W_GIE = W_CMD - WA'(1);
  localparam logic [WA-1:0] W_LEN = W_CMD - WA'(2);
  localparam logic [WA-1:0] W_RSV = W_LEN - WA'(RESERVED_WORDS);

  logic [WA-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    if (addr[1:0] != 2'b00)  sel = SEL_NONE;
    else if (word == W_CMD)  sel = SEL_CMD;
    else if (word == W_GIE)  sel = SEL_GIE;
    else if (word == W_LEN)  sel = SEL_LEN;
    else if (word >= W_RSV)  sel = SEL_NONE;
    else                     sel = SEL_FRAME;
  end
endmodule

// File: rtl/eth_txb_mem.sv
module eth_txb_mem #(
  parameter int DATA_W = 32,
  parameter int WA     = 9
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [WA-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [WA-1:0]     b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << WA;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) store[a_addr] <= a_wdata;
    if (a_re) a_rdata <= store[a_addr];
    b_rdata <= store[b_addr];
  end
endmodule

// File: rtl/eth_txb_ctrl.sv
module eth_txb_ctrl
  import eth_txb_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             burst,
  input  txb_sel_e         sel,
  input  logic [LEN_W-1:0] wdata,
  input  logic             done,
  output logic [LEN_W-1:0] len_q,
  output logic             gie_q,
  output logic             ien_q,
  output logic             busy_q,
  output logic             mac_q,
  output logic             irq_q
);
  logic wr_ok, cmd_wr, finish;
  assign wr_ok  = wr & ~burst;
  assign cmd_wr = wr_ok && (sel == SEL_CMD);
  assign finish = busy_q & done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      gie_q  <= 1'b0;
      ien_q  <= 1'b0;
      busy_q <= 1'b0;
      mac_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ok && sel == SEL_LEN) len_q <= wdata;
      if (wr_ok && sel == SEL_GIE) gie_q <= wdata[0];
      if (cmd_wr) ien_q <= wdata[CMD_IEN];
      if (finish) begin
        busy_q <= 1'b0;
        mac_q  <= 1'b0;
      end else if (cmd_wr && !busy_q && wdata[CMD_GO]) begin
        busy_q <= 1'b1;
        mac_q  <= wdata[CMD_MAC];
      end
      if (finish && gie_q && ien_q) irq_q <= 1'b1;
      else if (cmd_wr)              irq_q <= 1'b0;
    end
  end

  AST_BUSY_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done |=> busy_q);                                   // R6
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && done |=> !busy_q && !mac_q);                         // R6
  AST_IRQ_GATE:   assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(gie_q && ien_q && busy_q && done));     // R8
  AST_IRQ_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !(wr && !burst && sel == SEL_CMD) |=> irq_q);         // R9
  AST_BURST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr && burst |=> $stable(len_q) && $stable(gie_q) && $stable(ien_q)); // R10
endmodule

// File: rtl/eth_tx_buffer.sv
module eth_tx_buffer
  import eth_txb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_burst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              xmit_req,
  output logic              xmit_mac,
  output logic [LEN_W-1:0]  xmit_len,
  input  logic [ADDR_W-3:0] xmit_rd_addr,
  output logic [DATA_W-1:0] xmit_rd_data,
  input  logic              xmit_done,
  output logic              irq
);
  localparam int WA = ADDR_W - 2;

  txb_sel_e          sel, rsel_q;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata, reg_rd_q, reg_rd;
  logic [LEN_W-1:0]  len_q;
  logic              gie_q, ien_q, busy_q, mac_q, irq_q;

  eth_txb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .sel(sel)
  );

  assign mem_we = bus_wr && (sel == SEL_FRAME) && !busy_q;

  eth_txb_mem #(.DATA_W(DATA_W), .WA(WA)) u_mem (
    .clk(clk), .a_we(mem_we), .a_re(bus_rd), .a_addr(bus_addr[ADDR_W-1:2]),
    .a_wdata(bus_wdata), .a_rdata(mem_rdata),
    .b_addr(xmit_rd_addr), .b_rdata(xmit_rd_data)
  );

  eth_txb_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .burst(bus_burst), .sel(sel),
    .wdata(bus_wdata[LEN_W-1:0]), .done(xmit_done),
    .len_q(len_q), .gie_q(gie_q), .ien_q(ien_q),
    .busy_q(busy_q), .mac_q(mac_q), .irq_q(irq_q)
  );

  always_comb begin
    reg_rd = '0;
    if (!bus_burst) begin
      case (sel)
        SEL_LEN: reg_rd[LEN_W-1:0] = len_q;
        SEL_GIE: reg_rd[0] = gie_q;
        SEL_CMD: begin
          reg_rd[CMD_GO]  = busy_q;
          reg_rd[CMD_MAC] = mac_q;
          reg_rd[CMD_IEN] = ien_q;
        end
        default: reg_rd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsel_q   <= SEL_NONE;
      reg_rd_q <= '0;
    end else if (bus_rd) begin
      rsel_q   <= sel;
      reg_rd_q <= reg_rd;
    end
  end

  assign bus_rdata = (rsel_q == SEL_FRAME) ? mem_rdata : reg_rd_q;
  assign xmit_req  = busy_q;
  assign xmit_mac  = mac_q;
  assign xmit_len  = len_q;
  assign irq       = irq_q;

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmit_req) |-> $past(bus_wr && !bus_burst && sel == SEL_CMD && bus_wdata[CMD_GO])); // R5
  AST_MAC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_mac |-> xmit_req); // R5
endmodule

// File: tb/eth_tx_buffer_bench.sv
module eth_tx_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0, bus_burst = 0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        xmit_req, xmit_mac, xmit_done = 0, irq;
  logic [15:0] xmit_len;
  logic [8:0]  xmit_rd_addr = '0;
  logic [31:0] xmit_rd_data;

  int checks = 0, errors = 0;
  logic [31:0] model [505];
  logic [504:0] known = '0;

  localparam logic [10:0] A_LEN = 11'h7F4, A_GIE = 11'h7F8, A_CMD = 11'h7FC;

  always #5 clk = ~clk;

  eth_tx_buffer u_eth_tx_buffer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_burst(bus_burst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xmit_req(xmit_req), .xmit_mac(xmit_mac), .xmit_len(xmit_len),
    .xmit_rd_addr(xmit_rd_addr), .xmit_rd_data(xmit_rd_data),
    .xmit_done(xmit_done), .irq(irq)
  );

  function automatic logic [31:0] exp_len(input logic [31:0] d);
    return {16'h0, d[15:0]};
  endfunction
  function automatic logic [31:0] exp_cmd(input logic go, mac, ien);
    return {28'h0, ien, 1'b0, mac & go, go};
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d, input logic b);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_burst = b;
    @(negedge clk);
    bus_wr = 0; bus_burst = 0;
  endtask

  task automatic rd(input logic [10:0] a, input logic b, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; bus_burst = b;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 0; bus_burst = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xmit_done = 1;
    @(negedge clk); xmit_done = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check({29'h0, irq, xmit_req, xmit_mac}, 32'h0, "R1 outputs");
    check({16'h0, xmit_len}, 32'h0, "R1 length");
    rd(A_CMD, 0, d); check(d, 32'h0, "R1 cmd");
    rd(A_GIE, 0, d); check(d, 32'h0, "R1 gie");

    // R2 random frame fill and readback
    for (int k = 0; k < 40; k++) begin
      int w; logic [31:0] v;
      w = $urandom_range(504); v = $urandom;
      wr(11'(w * 4), v, k[0]);
      model[w] = v; known[w] = 1'b1;
    end
    for (int w = 0; w < 505; w++) begin
      if (known[w]) begin
        rd(11'(w * 4), w[0], d); check(d, model[w], "R2/R10 frame readback");
        xmit_rd_addr = 9'(w);
        @(negedge clk); check(xmit_rd_data, model[w], "R11 serialiser port");
      end
    end
    wr(11'h7E8, 32'hDEADBEEF, 0); rd(11'h7E8, 0, d); check(d, 32'h0, "R2 reserved word");
    rd(11'h002, 0, d); check(d, 32'h0, "R2 unaligned read");

    // R3 length register
    for (int k = 0; k < 5; k++) begin
      logic [31:0] v; v = $urandom;
      wr(A_LEN, v, 0);
      rd(A_LEN, 0, d); check(d, exp_len(v), "R3 length readback");
      check({16'h0, xmit_len}, exp_len(v), "R3 xmit_len");
    end
    // R4 gie
    wr(A_GIE, 32'hFFFF_FFFF, 0); rd(A_GIE, 0, d); check(d, 32'h1, "R4 gie set");
    wr(A_GIE, 32'hFFFF_FFFE, 0); rd(A_GIE, 0, d); check(d, 32'h0, "R4 gie clear");

    // R10 burst on control words
    wr(A_LEN, 32'h0000_05EA, 0);
    wr(A_LEN, 32'h0000_1234, 1); rd(A_LEN, 0, d); check(d, 32'h5EA, "R10 burst write ignored");
    rd(A_LEN, 1, d); check(d, 32'h0, "R10 burst read zero");
    wr(A_CMD, 32'h1, 1); check({31'h0, xmit_req}, 32'h0, "R10 burst cmd ignored");

    // R5/R6/R7 frame send
    pulse_done(); check({31'h0, xmit_req}, 32'h0, "R6 idle done ignored");
    wr(0, 32'hA5A5_0001, 0); model[0] = 32'hA5A5_0001;
    wr(A_CMD, 32'h1, 0);
    check({30'h0, xmit_req, xmit_mac}, 32'h2, "R5 frame start");
    rd(A_CMD, 0, d); check(d, exp_cmd(1, 0, 0), "R5 cmd readback");
    wr(0, 32'h1111_2222, 0);
    rd(0, 0, d); check(d, model[0], "R7 frame write discarded");
    wr(A_CMD, 32'h3, 0); rd(A_CMD, 0, d); check(d, exp_cmd(1, 0, 0), "R6 busy write no change");
    repeat (5) @(negedge clk);
    check({31'h0, xmit_req}, 32'h1, "R6 held until done");
    pulse_done(); rd(A_CMD, 0, d); check(d, 32'h0, "R6 cleared by done");
    // address load
    wr(A_CMD, 32'h3, 0);
    check({30'h0, xmit_req, xmit_mac}, 32'h3, "R5 address load start");
    rd(A_CMD, 0, d); check(d, exp_cmd(1, 1, 0), "R5 address load readback");
    pulse_done(); check({30'h0, xmit_req, xmit_mac}, 32'h0, "R6 address load done");

    // R8/R9 gating for all four combinations
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < 2; i++) begin
        logic e;
        e = (g == 1) && (i == 1);
        wr(A_GIE, 32'(g), 0);
        wr(A_CMD, (32'(i) << 3) | 32'h1, 0);
        check({31'h0, irq}, 32'h0, "R9 start write clears irq");
        pulse_done();
        check({31'h0, irq}, {31'h0, e}, "R8 irq gating");
        wr(A_LEN, 32'h40, 0);
        check({31'h0, irq}, {31'h0, e}, "R9 irq held");
        wr(A_CMD, 32'(i) << 3, 0);
        check({31'h0, irq}, 32'h0, "R9 cmd write clears irq");
      end
    end

    // R9 coincident completion and command write: set wins
    wr(A_GIE, 32'h1, 0);
    wr(A_CMD, 32'h9, 0);
    @(negedge clk);
    xmit_done = 1; bus_wr = 1; bus_addr = A_CMD; bus_wdata = 32'h8;
    @(negedge clk);
    xmit_done = 0; bus_wr = 0;
    check({30'h0, irq, xmit_req}, 32'h2, "R9 set wins over clear");

    summary();
  end
endmodule